// File: doc/BRIEF.md
# Halt and Auto-Wakeup Sequencer

This block manages the deepest low-power state of a small microcontroller core. When the CPU issues a halt request, the block parks the system in one of two halt flavours. In plain halt, every clock enable is removed. In auto-wakeup halt, only a slow self-clocked wakeup oscillator keeps running, so a periodic tick can bring the part back. A watchdog option can forbid halting altogether: with the watchdog running and that option set, a halt request turns into a watchdog reset pulse and the core keeps running.

A permitted wakeup event restarts the main oscillator, and the block then waits a start-up delay before the CPU and peripheral clocks return. The delay is 256 or 4096 cycles, chosen by a static option pin. The exit then takes one of two routes. A reset wake asks the core to fetch its reset vector. An interrupt wake asks the core to service the waking interrupt, and it raises the 2-bit interrupt-mask level to that interrupt's software priority until the return-from-interrupt pulse restores the earlier level. Peripherals that run from their own external clock can keep their clock enable through halt.

Top module: `halt_wake_seq`

## Requirements
- R1: A halt request taken in RUN enters AWU_HALT when `awu_en`=1 and HALT when `awu_en`=0, unless R2 applies. `state_o` encodes RUN=0, HALT=1, AWU_HALT=2, WAKE_DELAY=3.
- R2: A halt request with `wdg_active`=1 and `wdg_halt_opt`=1 gives a one-cycle `wdg_rst` pulse in the next cycle, and the state stays RUN.
- R3: In HALT, all four clock enables are 0. In AWU_HALT, `mosc_en`, `cpu_clk_en` and the gated peripheral enables are 0, and `awu_osc_en` is 1.
- R4: Wakeup sources are limited as follows. `irq_pending[0]` is the auto-wakeup tick and wakes only from AWU_HALT. Line i≥1 wakes only when bit i of the WAKE_MASK parameter is 1. `rst_wake` wakes from either halt state. Every other pending line leaves the state unchanged.
- R5: A wakeup moves the block to WAKE_DELAY. WAKE_DELAY lasts exactly 256 cycles when `long_dly_sel`=0 and 4096 cycles when it is 1. During it `mosc_en`=1 and `cpu_clk_en`=0, and `cpu_clk_en` returns in the first cycle after the last delay cycle.
- R6: In that first RUN cycle there is a single one-cycle pulse. It is `fetch_rst_vec` if `rst_wake` caused the wake, and otherwise `irq_svc` with `irq_svc_id` set to the waking line.
- R7: On the interrupt route, `imask` takes the waking line's priority (`irq_prio[2i+1:2i]`) in the first RUN cycle, and an `iret` pulse restores the earlier value. The reset route and reset both set `imask` to 3.
- R8: If several lines qualify at once, `rst_wake` wins over all of them, and among the interrupt lines the lowest index wins.
- R9: `awu_osc_en` stays 1 through WAKE_DELAY when the wake came from AWU_HALT, is 0 through WAKE_DELAY when it came from HALT, and is 0 in RUN.
- R10: A wakeup event during WAKE_DELAY is ignored and does not restart the count.
- R11: Peripheral clock enable i is 1 in every state while `periph_ext_clk[i]`=1. Otherwise it is 1 only in RUN.
- R12: After reset: `state_o`=RUN, `mosc_en`, `cpu_clk_en` and all `periph_clk_en` bits are 1, `awu_osc_en`=0, `imask`=3, and no pulse output is active.
- R13: A halt request outside RUN, and pending interrupts while in RUN, change no state and raise no exit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt request pulse from the CPU |
| awu_en | input | 1 | Selects auto-wakeup halt |
| wdg_active | input | 1 | Watchdog is running |
| wdg_halt_opt | input | 1 | Option: halt request becomes a watchdog reset |
| long_dly_sel | input | 1 | Static start-up delay choice (0: 256, 1: 4096) |
| rst_wake | input | 1 | Reset-type wake event |
| irq_pending | input | NUM_IRQ | Pending interrupt lines; line 0 is the auto-wakeup tick |
| irq_prio | input | 2*NUM_IRQ | Software priority per line |
| iret | input | 1 | Return-from-interrupt pulse |
| periph_ext_clk | input | NUM_PERIPH | Peripheral runs from an external clock |
| state_o | output | 2 | Current state code |
| mosc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| awu_osc_en | output | 1 | Wakeup RC oscillator enable |
| wdg_rst | output | 1 | Watchdog reset pulse |
| fetch_rst_vec | output | 1 | Reset-vector fetch request pulse |
| irq_svc | output | 1 | Interrupt service request pulse |
| irq_svc_id | output | $clog2(NUM_IRQ) | Line to be serviced |
| imask | output | 2 | Interrupt-mask level |

## Verification
The bench sweeps every interrupt line through both halt flavours and compares each outcome with a wake decision it computes from the mask. A design that ignored the mode for the tick line, or that honoured masked lines, would leave halt when it should stay. The bench counts the start-up delay edge by edge, for both lengths and with a stray wake injected mid-count. An off-by-one counter, or a counter that restarts on the stray event, gives a count of 255, 257 or more. It also drives simultaneous wake sources, and it issues halt requests with the watchdog option both set and cleared. A wrong priority order would report the wrong line, and a design that mishandled the watchdog option would halt when it should reset.

// File: rtl/hws_pkg.sv
package hws_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_AWU  = 2'd2,
      ST_WAKE = 2'd3
   } hws_state_e;

   localparam logic [1:0] IMASK_AT_RESET = 2'b11;
endpackage

// File: rtl/hws_wake_sel.sv
module hws_wake_sel #(
   parameter int                NUM_IRQ   = 8,
   parameter logic [NUM_IRQ-1:0] WAKE_MASK = '1,
   localparam int               IDW       = $clog2(NUM_IRQ)
) (
   input  logic [NUM_IRQ-1:0]   pending,
   input  logic [2*NUM_IRQ-1:0] prio_vec,
   input  logic                 awu_mode,
   output logic                 hit,
   output logic [IDW-1:0]       hit_id,
   output logic [1:0]           hit_prio
);
   logic [NUM_IRQ-1:0] qual;

   // line 0 is the tick, usable only when its oscillator runs
   assign qual[0] = pending[0] & awu_mode;

   genvar g;
   generate
      for (g = 1; g < NUM_IRQ; g++) begin : g_qual
         if (WAKE_MASK[g]) begin : g_on
            assign qual[g] = pending[g];
         end else begin : g_off
            assign qual[g] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      hit      = |qual;
      hit_id   = '0;
      hit_prio = prio_vec[1:0];
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (qual[i]) begin
            hit_id   = IDW'(i);
            hit_prio = prio_vec[2*i +: 2];
         end
      end
   end
endmodule

// File: rtl/hws_delay_ctr.sv
module hws_delay_ctr #(
   parameter int SHORT_DLY = 256,
   parameter int LONG_DLY  = 4096,
   localparam int CW       = $clog2(LONG_DLY)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic long_sel,
   output logic done
);
   localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DLY - 1);
   localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DLY - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = long_sel ? LONG_LAST : SHORT_LAST;
   assign done = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || done) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hws_clk_gate.sv
module hws_clk_gate
   import hws_pkg::*;
#(
   parameter int NUM_PERIPH = 4
) (
   input  hws_state_e            state,
   input  logic                  from_awu,
   input  logic [NUM_PERIPH-1:0] ext_clk,
   output logic                  mosc_en,
   output logic [NUM_PERIPH-1:0] periph_en,
   output logic                  cpu_en,
   output logic                  awu_en
);
   logic running;

   assign running = (state == ST_RUN);
   assign cpu_en  = running;
   assign mosc_en = running || (state == ST_WAKE);
   assign awu_en  = (state == ST_AWU) || ((state == ST_WAKE) && from_awu);

   genvar p;
   generate
      for (p = 0; p < NUM_PERIPH; p++) begin : g_per
         assign periph_en[p] = running | ext_clk[p];
      end
   endgenerate
endmodule

// File: rtl/hws_mask_ctl.sv
module hws_mask_ctl
   import hws_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       svc_set,
   input  logic [1:0] svc_prio,
   input  logic       rst_path,
   input  logic       iret,
   output logic [1:0] imask
);
   logic [1:0] saved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imask <= IMASK_AT_RESET;
         saved <= IMASK_AT_RESET;
      end else if (rst_path) begin
         imask <= IMASK_AT_RESET;
         saved <= IMASK_AT_RESET;
      end else if (svc_set) begin
         saved <= imask;
         imask <= svc_prio;
      end else if (iret) begin
         imask <= saved;
      end
   end
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
   import hws_pkg::*;
#(
   parameter int                 NUM_IRQ    = 8,
   parameter int                 NUM_PERIPH = 4,
   parameter int                 SHORT_DLY  = 256,
   parameter int                 LONG_DLY   = 4096,
   parameter logic [NUM_IRQ-1:0] WAKE_MASK  = 8'hA5,
   localparam int                IDW        = $clog2(NUM_IRQ)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  halt_req,
   input  logic                  awu_en,
   input  logic                  wdg_active,
   input  logic                  wdg_halt_opt,
   input  logic                  long_dly_sel,
   input  logic                  rst_wake,
   input  logic [NUM_IRQ-1:0]    irq_pending,
   input  logic [2*NUM_IRQ-1:0]  irq_prio,
   input  logic                  iret,
   input  logic [NUM_PERIPH-1:0] periph_ext_clk,
   output logic [1:0]            state_o,
   output logic                  mosc_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  cpu_clk_en,
   output logic                  awu_osc_en,
   output logic                  wdg_rst,
   output logic                  fetch_rst_vec,
   output logic                  irq_svc,
   output logic [IDW-1:0]        irq_svc_id,
   output logic [1:0]            imask
);
   initial begin
      if (NUM_IRQ < 2 || NUM_PERIPH < 1)
         $fatal(1, "halt_wake_seq: NUM_IRQ must be >= 2 and NUM_PERIPH >= 1");
      if (SHORT_DLY < 2 || SHORT_DLY >= LONG_DLY)
         $fatal(1, "halt_wake_seq: need 2 <= SHORT_DLY < LONG_DLY");
   end

   hws_state_e     state, state_nx;
   logic           from_awu;
   logic           cause_rst;
   logic [IDW-1:0] wake_id;
   logic [1:0]     wake_prio;
   logic           wdg_rst_q, fetch_q, svc_q;

   logic           halted;
   logic           sel_hit;
   logic [IDW-1:0] sel_id;
   logic [1:0]     sel_prio;
   logic           wake_now;
   logic           halt_to_rst;
   logic           dly_done;

   assign halted      = (state == ST_HALT) || (state == ST_AWU);
   assign wake_now    = halted && (rst_wake || sel_hit);
   assign halt_to_rst = wdg_active && wdg_halt_opt;

   hws_wake_sel #(
      .NUM_IRQ   (NUM_IRQ),
      .WAKE_MASK (WAKE_MASK)
   ) u_sel (
      .pending  (irq_pending),
      .prio_vec (irq_prio),
      .awu_mode (state == ST_AWU),
      .hit      (sel_hit),
      .hit_id   (sel_id),
      .hit_prio (sel_prio)
   );

   hws_delay_ctr #(
      .SHORT_DLY (SHORT_DLY),
      .LONG_DLY  (LONG_DLY)
   ) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state == ST_WAKE),
      .long_sel (long_dly_sel),
      .done     (dly_done)
   );

   hws_clk_gate #(
      .NUM_PERIPH (NUM_PERIPH)
   ) u_gate (
      .state     (state),
      .from_awu  (from_awu),
      .ext_clk   (periph_ext_clk),
      .mosc_en   (mosc_en),
      .periph_en (periph_clk_en),
      .cpu_en    (cpu_clk_en),
      .awu_en    (awu_osc_en)
   );

   hws_mask_ctl u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .svc_set  (dly_done && !cause_rst),
      .svc_prio (wake_prio),
      .rst_path (dly_done && cause_rst),
      .iret     (iret && (state == ST_RUN)),
      .imask    (imask)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_RUN: begin
            if (halt_req && !halt_to_rst)
               state_nx = awu_en ? ST_AWU : ST_HALT;
         end
         ST_HALT, ST_AWU: begin
            if (wake_now)
               state_nx = ST_WAKE;
         end
         ST_WAKE: begin
            if (dly_done)
               state_nx = ST_RUN;
         end
         default: state_nx = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         from_awu  <= 1'b0;
         cause_rst <= 1'b0;
         wake_id   <= '0;
         wake_prio <= '0;
         wdg_rst_q <= 1'b0;
         fetch_q   <= 1'b0;
         svc_q     <= 1'b0;
      end else begin
         state     <= state_nx;
         wdg_rst_q <= (state == ST_RUN) && halt_req && halt_to_rst;
         fetch_q   <= dly_done && cause_rst;
         svc_q     <= dly_done && !cause_rst;
         if (wake_now) begin
            from_awu  <= (state == ST_AWU);
            cause_rst <= rst_wake;
            wake_id   <= sel_id;
            wake_prio <= sel_prio;
         end
      end
   end

   assign state_o       = state;
   assign wdg_rst       = wdg_rst_q;
   assign fetch_rst_vec = fetch_q;
   assign irq_svc       = svc_q;
   assign irq_svc_id    = wake_id;
endmodule

// File: rtl/hws_checker.sv
module hws_checker #(
   parameter int SHORT_DLY = 256,
   parameter int LONG_DLY  = 4096,
   localparam int DW       = $clog2(LONG_DLY) + 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] state_o,
   input logic       halt_req,
   input logic       awu_en,
   input logic       wdg_active,
   input logic       wdg_halt_opt,
   input logic       long_dly_sel,
   input logic       mosc_en,
   input logic       cpu_clk_en,
   input logic       awu_osc_en,
   input logic       wdg_rst,
   input logic       fetch_rst_vec,
   input logic       irq_svc
);
   logic [DW-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              wcnt <= '0;
      else if (state_o == 2'd3) wcnt <= wcnt + 1'b1;
      else                     wcnt <= '0;
   end

   AST_AWU_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && halt_req && !(wdg_active && wdg_halt_opt) && awu_en) |=> state_o == 2'd2); // R1

   AST_WDG_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && halt_req && wdg_active && wdg_halt_opt) |=> (state_o == 2'd0 && wdg_rst)); // R2

   AST_AWU_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd2 |-> (!mosc_en && !cpu_clk_en && awu_osc_en)); // R3

   AST_DELAY_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd3 |-> (mosc_en && !cpu_clk_en)); // R5

   AST_DELAY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == 2'd3 && state_o == 2'd0) |->
         (wcnt == DW'(long_dly_sel ? LONG_DLY : SHORT_DLY) && cpu_clk_en)); // R5

   AST_ONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_o) == 2'd3 && state_o == 2'd0) |-> $countones({fetch_rst_vec, irq_svc}) == 1); // R6

   AST_AWU_OFF_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 2'd0 |-> !awu_osc_en); // R9
endmodule

bind halt_wake_seq hws_checker #(
   .SHORT_DLY (SHORT_DLY),
   .LONG_DLY  (LONG_DLY)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .state_o       (state_o),
   .halt_req      (halt_req),
   .awu_en        (awu_en),
   .wdg_active    (wdg_active),
   .wdg_halt_opt  (wdg_halt_opt),
   .long_dly_sel  (long_dly_sel),
   .mosc_en       (mosc_en),
   .cpu_clk_en    (cpu_clk_en),
   .awu_osc_en    (awu_osc_en),
   .wdg_rst       (wdg_rst),
   .fetch_rst_vec (fetch_rst_vec),
   .irq_svc       (irq_svc)
);

// File: tb/halt_wake_seq_test.sv
`timescale 1ns/1ps
module halt_wake_seq_test;
   localparam int         NI   = 8;
   localparam int         NP   = 4;
   localparam int         SD   = 256;
   localparam int         LD   = 4096;
   localparam logic [7:0] MASK = 8'hA5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          halt_req = 0, awu_en = 0, wdg_active = 0, wdg_halt_opt = 0;
   logic          long_dly_sel = 0, rst_wake = 0, iret = 0;
   logic [NI-1:0] irq_pending = '0;
   logic [2*NI-1:0] irq_prio;
   logic [NP-1:0] periph_ext_clk = '0;
   logic [1:0]    state_o, imask;
   logic          mosc_en, cpu_clk_en, awu_osc_en, wdg_rst, fetch_rst_vec, irq_svc;
   logic [NP-1:0] periph_clk_en;
   logic [2:0]    irq_svc_id;

   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;

   halt_wake_seq #(.NUM_IRQ(NI), .NUM_PERIPH(NP), .SHORT_DLY(SD), .LONG_DLY(LD),
                   .WAKE_MASK(MASK)) uut (.*);

   function automatic logic [1:0] prio_of(int i);
      return 2'((i + 1) % 4);
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic enter_halt(input bit mode);
      awu_en = mode; halt_req = 1; tick(); halt_req = 0;
      chk(state_o == (mode ? 2 : 1), "R1 halt entry", state_o, mode ? 2 : 1);
   endtask

   // wake stimulus must already be driven; measures delay and exit
   task automatic run_exit(input bit exp_rst, input int id, input bit mode, input bit lng);
      int n = 0;
      long_dly_sel = lng;
      tick();
      chk(state_o == 3, "R5 enters delay", state_o, 3);
      irq_pending = '0; rst_wake = 0;
      while (state_o == 3 && n < 5000) begin
         if (n == 10) irq_pending = 8'h04; else irq_pending = '0;
         if (n == 5) begin
            chk(mosc_en && !cpu_clk_en, "R5 delay clocks", cpu_clk_en, 0);
            chk(awu_osc_en == mode, "R9 awu osc in delay", awu_osc_en, mode);
         end
         tick(); n++;
      end
      irq_pending = '0;
      chk(n == (lng ? LD : SD), "R5 R10 delay length", n, lng ? LD : SD);
      chk(cpu_clk_en && !awu_osc_en, "R9 run clocks", awu_osc_en, 0);
      if (exp_rst) begin
         chk(fetch_rst_vec && !irq_svc, "R6 reset route", fetch_rst_vec, 1);
         chk(imask == 3, "R7 imask on reset route", imask, 3);
      end else begin
         chk(irq_svc && !fetch_rst_vec && irq_svc_id == id, "R6 irq route id", irq_svc_id, id);
         chk(imask == prio_of(id), "R7 imask raised", imask, prio_of(id));
      end
      tick();
      chk(!irq_svc && !fetch_rst_vec, "R6 pulse width", irq_svc, 0);
      if (!exp_rst) begin
         iret = 1; tick(); iret = 0;
         chk(imask == 3, "R7 imask restored", imask, 3);
      end
   endtask

   initial begin
      for (int i = 0; i < NI; i++) irq_prio[2*i +: 2] = prio_of(i);
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #1; tick(); rst_n = 1; tick();
      // R12 reset state
      chk(state_o == 0 && mosc_en && cpu_clk_en && periph_clk_en == 4'hF && !awu_osc_en,
          "R12 reset enables", state_o, 0);
      chk(imask == 3 && !wdg_rst && !fetch_rst_vec && !irq_svc, "R12 reset outputs", imask, 3);

      // R13 interrupts in RUN
      irq_pending = 8'hFF; tick(); tick(); irq_pending = '0;
      chk(state_o == 0 && !irq_svc, "R13 irq in run", state_o, 0);

      // R2 watchdog forbids halt
      wdg_active = 1; wdg_halt_opt = 1; awu_en = 1; halt_req = 1; tick(); halt_req = 0;
      chk(wdg_rst && state_o == 0, "R2 watchdog reset", state_o, 0);
      tick();
      chk(!wdg_rst, "R2 pulse width", wdg_rst, 0);
      wdg_halt_opt = 0;

      // sweep: every line in both halt modes
      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < NI; i++) begin
            bit exp_w;
            enter_halt(m[0]);
            if (m == 0) chk(!mosc_en && !cpu_clk_en && !awu_osc_en && periph_clk_en == 0,
                            "R3 plain halt clocks", awu_osc_en, 0);
            else chk(!mosc_en && !cpu_clk_en && awu_osc_en, "R3 awu halt clocks", awu_osc_en, 1);
            exp_w = (i == 0) ? m[0] : MASK[i];
            irq_pending = 8'(1 << i);
            if (exp_w) begin
               run_exit(0, i, m[0], (m == 1 && i == 5));
            end else begin
               tick(); tick(); tick(); irq_pending = '0;
               chk(state_o == (m ? 2 : 1), "R4 masked line ignored", state_o, m ? 2 : 1);
               rst_wake = 1;
               run_exit(1, 0, m[0], 0);
            end
         end
      end

      // R8 priority among lines and over reset wake
      enter_halt(0);
      irq_pending = 8'hA4;
      run_exit(0, 2, 0, 0);
      enter_halt(1);
      irq_pending = 8'h81; rst_wake = 1;
      run_exit(1, 0, 1, 1);

      // R13 halt request outside RUN; R11 external clock bypass
      enter_halt(1);
      periph_ext_clk = 4'b0101;
      awu_en = 0; halt_req = 1; tick(); halt_req = 0; tick();
      chk(state_o == 2, "R13 halt req in halt", state_o, 2);
      chk(periph_clk_en == 4'b0101, "R11 ext clock bypass", periph_clk_en, 5);
      irq_pending = 8'h01;
      run_exit(0, 0, 1, 0);
      periph_ext_clk = '0;
      chk(periph_clk_en == 4'hF, "R11 run enables", periph_clk_en, 15);

      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule